// File: doc/BRIEF.md
# HS Byte Word Aligner

This block sits behind a 1:8 deserializer on one lane of a high-speed serial receiver. The deserializer delivers 8-bit words whose byte boundary falls at an arbitrary bit position. The aligner watches the bit stream for the sync byte 0xB8, which can start at any of eight bit offsets and straddle two words. On a match it freezes that offset and then delivers correctly framed bytes with a valid flag.

A burst starts when the enable input goes high. While enable is low the aligner is held cleared; each new rising edge starts a fresh search. A parameter selects 16-bit output, where two framed bytes are packed per output word with the earlier byte in the low half. A second parameter turns alignment off, and the raw deserializer words then pass straight through.

Top module: `hs_byte_aligner`

## Requirements
- R1: At each clock edge where `en_i` is low, `locked_o` and `valid_o` become 0 and stay 0 for as long as `en_i` stays low. Any lock found earlier is discarded.
- R2: With `en_i` high and no lock held, the block checks the 16-bit window {current word, previous word} for the byte 0xB8 at bit offsets 0 to 7. Bit 0 of each word is the first serial bit, and the byte at offset k is window bits k+7..k. `locked_o` rises in the cycle after the window that holds the last bit of the sync byte is presented. Without a match, `locked_o` stays 0.
- R4: In 8-bit mode (OUT_WIDE=0), `valid_o` rises one cycle after `locked_o`. It carries the byte that follows the sync byte. Each later cycle carries the next byte of the stream, and the sync byte itself is never output.
- R5: Once locked, the offset stays frozen until `en_i` falls. 0xB8 patterns in the payload at the locked offset or at any other offset do not change the framing.
- R6: In 16-bit mode (OUT_WIDE=1), `valid_o` pulses every second cycle, starting two cycles after `locked_o` rises. Each word holds two consecutive framed bytes, with the earlier byte in bits 7..0 and the later byte in bits 15..8.
- R7: With ALIGN_EN=0, no search is made. `locked_o` rises one cycle after `en_i` goes high. From the next cycle on, `data_o` carries the word presented in the previous cycle, with `valid_o` high.
- R8: While `rst_ni` is low, `data_o`, `valid_o` and `locked_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Burst enable; low clears the lock, high searches |
| word_i | input | W | Raw deserializer word, bit 0 received first |
| data_o | output | W or 2W | Framed byte, or packed byte pair |
| valid_o | output | 1 | data_o carries framed data |
| locked_o | output | 1 | Sync found, offset frozen |

## Verification
Say the window that completes the sync byte is presented in step j. Then `locked_o` is due after the edge of step j, the first framed byte after step j+1, and the first packed pair after step j+2. The raw pass-through shows each word after the edge at which it is presented. The bench drives inputs at the falling edge and samples 1 ns after the rising edge. For each step it works out the expected value from a bit-level model of the serial stream: it locates the sync bit position, converts it to a step index, and compares only against that schedule. The leading bytes are random but screened so that no earlier 0xB8 appears. The payload deliberately holds 0xB8 patterns at several offsets.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
  localparam int unsigned HSA_W = 8;
  localparam logic [HSA_W-1:0] HSA_SYNC = 8'hB8;
endpackage

// File: rtl/hsa_window.sv
module hsa_window #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   word_i,
  output logic [2*W-1:0] win_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= word_i;
  end

  // earlier word in low half: bit 0 is oldest serial bit
  assign win_o = {word_i, prev_q};
endmodule

// File: rtl/hsa_sync_detect.sv
module hsa_sync_detect #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] SYNC = 8'hB8,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic [2*W-1:0] win_i,
  output logic           found_o,
  output logic [OFF_W-1:0] off_o
);
  logic [W-1:0] hit;

  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit[k] = (win_i[k +: W] == SYNC);
  end

  // lowest offset = earliest serial position wins
  always_comb begin
    found_o = 1'b0;
    off_o   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found_o = 1'b1;
        off_o   = OFF_W'(k);
      end
    end
  end
endmodule

// File: rtl/hsa_lock_ctrl.sv
module hsa_lock_ctrl #(
  parameter int unsigned W     = 8,
  parameter bit          ALIGN = 1'b1,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             found_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             locked_o,
  output logic [OFF_W-1:0] off_o
);
  logic             locked_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      off_q    <= '0;
    end else if (!en_i) begin
      locked_q <= 1'b0;
      off_q    <= '0;
    end else if (!locked_q) begin
      if (!ALIGN) begin
        locked_q <= 1'b1;
      end else if (found_i) begin
        locked_q <= 1'b1;
        off_q    <= off_i;
      end
    end
  end

  assign locked_o = locked_q;
  assign off_o    = off_q;

  // R1
  en_low_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !locked_q);

  // R5
  off_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && en_i) |=> (locked_q && $stable(off_q)));

  if (ALIGN) begin : g_align_chk
    // R2
    lock_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_q) |-> $past(found_i));
  end
endmodule

// File: rtl/hsa_pack.sv
module hsa_pack #(
  parameter int unsigned W    = 8,
  parameter bit          WIDE = 1'b0,
  localparam int unsigned OUT_W = WIDE ? 2 * W : W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [W-1:0]     byte_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] data_q;
  logic             valid_q;

  if (WIDE) begin : g_wide
    logic         phase_q;
    logic [W-1:0] low_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q  <= '0;
        valid_q <= 1'b0;
        phase_q <= 1'b0;
        low_q   <= '0;
      end else if (!take_i) begin
        valid_q <= 1'b0;
        phase_q <= 1'b0;
      end else if (!phase_q) begin
        low_q   <= byte_i;
        phase_q <= 1'b1;
        valid_q <= 1'b0;
      end else begin
        data_q  <= {byte_i, low_q};
        phase_q <= 1'b0;
        valid_q <= 1'b1;
      end
    end

    // R6
    wide_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |=> !valid_q);
  end else begin : g_narrow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q  <= '0;
        valid_q <= 1'b0;
      end else if (!take_i) begin
        valid_q <= 1'b0;
      end else begin
        data_q  <= OUT_W'(byte_i);
        valid_q <= 1'b1;
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/hs_byte_aligner.sv
module hs_byte_aligner
  import hsa_pkg::*;
#(
  parameter int unsigned W        = HSA_W,
  parameter logic [W-1:0] SYNC    = HSA_SYNC,
  parameter bit          ALIGN_EN = 1'b1,
  parameter bit          OUT_WIDE = 1'b0,
  localparam int unsigned OFF_W   = $clog2(W),
  localparam int unsigned OUT_W   = OUT_WIDE ? 2 * W : W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     word_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o,
  output logic             locked_o
);
  logic             found;
  logic [OFF_W-1:0] off_new;
  logic [OFF_W-1:0] off_lk;
  logic [W-1:0]     framed;
  logic             locked;

  if (ALIGN_EN) begin : g_align
    logic [2*W-1:0] win;

    hsa_window #(.W(W)) i_window (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .word_i (word_i),
      .win_o  (win)
    );

    hsa_sync_detect #(.W(W), .SYNC(SYNC)) i_detect (
      .win_i   (win),
      .found_o (found),
      .off_o   (off_new)
    );

    assign framed = win[off_lk +: W];
  end else begin : g_raw
    assign found   = 1'b0;
    assign off_new = '0;
    assign framed  = word_i;
  end

  hsa_lock_ctrl #(.W(W), .ALIGN(ALIGN_EN)) i_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .found_i  (found),
    .off_i    (off_new),
    .locked_o (locked),
    .off_o    (off_lk)
  );

  hsa_pack #(.W(W), .WIDE(OUT_WIDE)) i_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (locked && en_i),
    .byte_i  (framed),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  assign locked_o = locked;

  // R1
  en_low_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);

  // R4
  valid_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o);

  // R4
  valid_after_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(locked_o));

  // R8
  always_comb begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!valid_o && !locked_o);
    end
  end
endmodule

// File: tb/test_hs_byte_aligner.sv
`timescale 1ns/1ps
module test_hs_byte_aligner;
  localparam logic [7:0] SYNC = 8'hB8;

  typedef struct packed {
    logic [2:0] off;
    logic [3:0] lead;
    logic [4:0] plen;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 4'd1,  5'd10},
    '{3'd1, 4'd3,  5'd12},
    '{3'd2, 4'd0,  5'd9},
    '{3'd3, 4'd5,  5'd14},
    '{3'd4, 4'd2,  5'd11},
    '{3'd5, 4'd7,  5'd10},
    '{3'd6, 4'd4,  5'd13},
    '{3'd7, 4'd9,  5'd16}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_s = 1'b0;
  logic [7:0] word_s = '0;

  logic [7:0]  n_data, r_data;
  logic [15:0] w_data;
  logic n_valid, n_locked, w_valid, w_locked, r_valid, r_locked;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic bits [0:1023];
  logic [7:0] pay [0:31];
  logic [7:0] wrd [0:127];

  always #2 clk = ~clk;

  hs_byte_aligner i_hs_byte_aligner (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_s), .word_i(word_s),
    .data_o(n_data), .valid_o(n_valid), .locked_o(n_locked));

  hs_byte_aligner #(.OUT_WIDE(1'b1)) i_hs_byte_aligner_wide (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_s), .word_i(word_s),
    .data_o(w_data), .valid_o(w_valid), .locked_o(w_locked));

  hs_byte_aligner #(.ALIGN_EN(1'b0)) i_hs_byte_aligner_raw (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_s), .word_i(word_s),
    .data_o(r_data), .valid_o(r_valid), .locked_o(r_locked));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] w);
    @(negedge clk);
    en_s = en;
    word_s = w;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] byte_at(input int p);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = (p + b < 0) ? 1'b0 : bits[p + b];
    return r;
  endfunction

  task automatic idle_chk(input string req);
    chk(req, {15'd0, n_locked}, 16'd0);
    chk(req, {15'd0, n_valid}, 16'd0);
    chk(req, {14'd0, w_locked, w_valid}, 16'd0);
    chk(req, {14'd0, r_locked, r_valid}, 16'd0);
  endtask

  task automatic run_vec(input vec_t v);
    int k, s, j, n, q;
    bit clean;
    k = int'(v.off);
    s = k + 8 * int'(v.lead);
    j = s / 8 + 1;
    n = j + int'(v.plen) + 1;
    for (int t = 0; t < 50; t++) begin
      for (int b = 0; b < 8 * n + 8; b++) bits[b] = 1'($urandom);
      for (int p = 0; p < int'(v.plen); p++) pay[p] = 8'($urandom);
      pay[3] = SYNC;
      pay[5] = 8'hC0;  // with pay[6], 0xB8 at offset 3
      pay[6] = 8'h05;
      if (t == 49) for (int b = 0; b < s; b++) bits[b] = 1'b0;
      for (int b = 0; b < 8; b++) bits[s + b] = SYNC[b];
      for (int p = 0; p < int'(v.plen); p++)
        for (int b = 0; b < 8; b++) bits[s + 8 + 8 * p + b] = pay[p][b];
      clean = 1'b1;
      for (int p = -8; p < s; p++) if (byte_at(p) == SYNC) clean = 1'b0;
      if (clean) break;
    end
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) wrd[i][b] = bits[8 * i + b];

    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    idle_chk("R1");

    for (int i = 0; i < n; i++) begin
      step(1'b1, wrd[i]);
      if (i < j) begin
        chk("R2", {15'd0, n_locked}, 16'd0);
        chk("R2", {15'd0, n_valid}, 16'd0);
      end else if (i == j) begin
        chk("R2", {15'd0, n_locked}, 16'd1);
        chk("R4", {15'd0, n_valid}, 16'd0);
        chk("R2", {15'd0, w_locked}, 16'd1);
      end else begin
        q = i - j - 1;
        chk(q >= 3 ? "R5" : "R4", {7'd0, n_valid, n_data}, {8'd1, pay[q]});
        if (q % 2 == 1) begin
          chk("R6", {15'd0, w_valid}, 16'd1);
          chk("R6", w_data, {pay[q], pay[q - 1]});
        end else begin
          chk("R6", {15'd0, w_valid}, 16'd0);
        end
      end
      if (i == 0) begin
        chk("R7", {14'd0, r_locked, r_valid}, 16'b10);
      end else begin
        chk("R7", {7'd0, r_valid, r_data}, {8'd1, wrd[i]});
      end
    end

    step(1'b0, 8'h5A);
    idle_chk("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8", {7'd0, n_valid, n_data}, 16'd0);
    chk("R8", w_data, 16'd0);
    chk("R8", {14'd0, w_valid, w_locked}, 16'd0);
    chk("R8", {6'd0, r_valid, r_locked, r_data}, 16'd0);
    chk("R8", {15'd0, n_locked}, 16'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int v = 0; v < 8; v++) run_vec(VECS[v]);

    // R4: byte-aligned sync, then payload byte
    step(1'b0, 8'h00);
    step(1'b1, SYNC);
    chk("R2", {15'd0, n_locked}, 16'd0);
    step(1'b1, 8'h11);
    chk("R2", {15'd0, n_locked}, 16'd1);
    step(1'b1, 8'h22);
    chk("R4", {7'd0, n_valid, n_data}, 16'h0111);
    // R1: drop mid-burst clears lock
    step(1'b0, 8'h33);
    idle_chk("R1");
    // R2: re-enabled without sync stays unlocked
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 8'h00);
      chk("R2", {14'd0, n_locked, n_valid}, 16'd0);
      chk("R2", {14'd0, w_locked, w_valid}, 16'd0);
    end
    step(1'b0, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule